// File: doc/BRIEF.md
# Programmable Display Timing Engine

This block generates the raster timing for a display panel from a bank of software-written registers. A frame position counter advances once per pixel clock from the start of the frame. A horizontal pixel counter runs beside it and wraps once per line. Both positions are compared against programmed limits to produce horizontal sync, vertical sync, data enable, a pixel request, a border flag and a one-cycle fetch trigger. All vertical limits are absolute pixel-clock counts from frame start. Software therefore programs the line period already multiplied in, together with any sync skew offset.

A sub-window can be enabled inside the display region, separately in x and in y. Display pixels inside the window request data from upstream. Display pixels outside it are filled with a programmable border color. When upstream has no valid pixel for a requested position, the underflow color is substituted. Frame and line counters are readable through the same register port while the engine runs.

Top module: `disp_timing_engine`

## Requirements
- R1: The register port writes on a clock edge with `reg_wr_en` high and reads combinationally at `reg_addr`. Offsets: 0x000 run (bit 0), 0x004 config (bit 29 x-window, bit 30 y-window, bit 31 fetch), 0x008 {line period[31:16], hsync width[15:0]}, 0x00C frame period, 0x014 vsync width, 0x01C/0x024 display y start/end, 0x02C/0x034 window y start/end, 0x03C {display last x[31:16], first x[15:0]}, 0x040 {window end x[31:16], start x[15:0]}, 0x044 border color, 0x048 underflow color, 0x04C skew, 0x050 polarity, 0x0A8 counter enables, 0x0AC frame count, 0x0B0 line count, 0x170 fetch position. Unmapped offsets read 0 and ignore writes.
- R2: While run is 0, both positions and both counters are held at 0, the counters read 0, pix_req_o, border_o and fetch_o are 0, and each sync/enable output rests at its polarity bit.
- R3: After the edge that sets run, `pos_f_o`/`pos_x_o` show 0 from the following edge on and then advance by 1 per clock. x wraps after line period minus 1, or when the frame position wraps. The frame position wraps after frame period minus 1.
- R4: Raw hsync is active while x < hsync width.
- R5: Raw vsync is active while skew <= frame position < skew + vsync width.
- R6: Raw data enable is active while display y start <= frame position <= display y end and first x <= x <= last x, both ranges inclusive.
- R7: With config bit 29 set, the window requires window start x <= x <= window end x. With bit 30 set, it requires window y start <= frame position <= window y end. A display pixel inside the window raises pix_req_o; a display pixel outside it raises border_o. With both bits clear, pix_req_o equals data enable.
- R8: `pix_o` is the border color when border_o is high. When pix_req_o is high it is pix_in if pix_valid is high, otherwise the underflow color, with underflow_o high. In all other cases it is 0.
- R9: Polarity bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable.
- R10: With config bit 31 set, fetch_o pulses for one clock when the frame position equals the fetch position.
- R11: Counter enable bit 0 makes the frame count increase at each frame wrap. Bit 1 makes the line count increase at each x wrap. The line count returns to 0 at every frame wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr |
| pix_in | input | 24 | Upstream pixel value |
| pix_valid | input | 1 | Upstream pixel available |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pix_req_o | output | 1 | Pixel requested from upstream |
| border_o | output | 1 | Display pixel outside window |
| fetch_o | output | 1 | One-cycle fetch trigger |
| underflow_o | output | 1 | Requested pixel missing |
| pix_o | output | 24 | Outgoing pixel value |
| pos_x_o | output | 16 | x position of current outputs |
| pos_f_o | output | 32 | Frame position of current outputs |

## Verification
A register write takes effect on its edge, and the positional outputs are registered once more. Sync, enable, flags and position therefore show position 0 one edge after the edge that captured run. From there they show position t after t more edges, and the bench keeps its own cycle index t against which every table row is placed. Register reads, the counter reads and the pixel mux are combinational, so the bench drives the address or pix_valid at a falling edge and compares a moment later in the same cycle. At that point each counter reflects position t+1, which the expected counts allow for.

// File: rtl/dte_pkg.sv
package dte_pkg;
    localparam int XW = 16;   // x and line-period width
    localparam int PW = 32;   // frame position width
    localparam int CW = 24;   // pixel color width
    localparam int FW = 32;   // frame counter width
    localparam int AW = 12;   // register offset width
    localparam int DW = 32;   // register data width

    localparam logic [AW-1:0] OFS_RUN    = 12'h000;
    localparam logic [AW-1:0] OFS_CFG    = 12'h004;
    localparam logic [AW-1:0] OFS_LINE   = 12'h008;
    localparam logic [AW-1:0] OFS_FRAME  = 12'h00C;
    localparam logic [AW-1:0] OFS_VSW    = 12'h014;
    localparam logic [AW-1:0] OFS_DYS    = 12'h01C;
    localparam logic [AW-1:0] OFS_DYE    = 12'h024;
    localparam logic [AW-1:0] OFS_WYS    = 12'h02C;
    localparam logic [AW-1:0] OFS_WYE    = 12'h034;
    localparam logic [AW-1:0] OFS_DX     = 12'h03C;
    localparam logic [AW-1:0] OFS_WX     = 12'h040;
    localparam logic [AW-1:0] OFS_BORDER = 12'h044;
    localparam logic [AW-1:0] OFS_UNDER  = 12'h048;
    localparam logic [AW-1:0] OFS_SKEW   = 12'h04C;
    localparam logic [AW-1:0] OFS_POL    = 12'h050;
    localparam logic [AW-1:0] OFS_CNTEN  = 12'h0A8;
    localparam logic [AW-1:0] OFS_FCNT   = 12'h0AC;
    localparam logic [AW-1:0] OFS_LCNT   = 12'h0B0;
    localparam logic [AW-1:0] OFS_FETCH  = 12'h170;

    localparam int BIT_XWIN  = 29;
    localparam int BIT_YWIN  = 30;
    localparam int BIT_FETCH = 31;
    localparam int HI_LSB    = 16;

    // Counting controls used by the position counters.
    typedef struct packed {
        logic          run;
        logic [XW-1:0] line_period;
        logic [PW-1:0] frame_period;
        logic [1:0]    cnt_en;
    } dte_ctl_t;

    // Comparison limits and colors used by the output stage.
    typedef struct packed {
        logic          xwin_en;
        logic          ywin_en;
        logic          fetch_en;
        logic [XW-1:0] hs_width;
        logic [XW-1:0] dx_first;
        logic [XW-1:0] dx_last;
        logic [XW-1:0] wx_start;
        logic [XW-1:0] wx_end;
        logic [PW-1:0] vs_width;
        logic [PW-1:0] dy_start;
        logic [PW-1:0] dy_end;
        logic [PW-1:0] wy_start;
        logic [PW-1:0] wy_end;
        logic [PW-1:0] skew;
        logic [PW-1:0] fetch_pos;
        logic [CW-1:0] border;
        logic [CW-1:0] underflow;
        logic [2:0]    pol;
    } dte_shape_t;

    typedef struct packed {
        dte_ctl_t   ctl;
        dte_shape_t shape;
    } dte_cfg_t;
endpackage

// File: rtl/dte_regbank.sv
module dte_regbank
    import dte_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [FW-1:0] frame_cnt,
    input  logic [XW-1:0] line_cnt,
    output logic [DW-1:0] rdata,
    output dte_cfg_t      cfg_o
);
    dte_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                OFS_RUN:    cfg_d.ctl.run = wdata[0];
                OFS_CFG: begin
                    cfg_d.shape.xwin_en  = wdata[BIT_XWIN];
                    cfg_d.shape.ywin_en  = wdata[BIT_YWIN];
                    cfg_d.shape.fetch_en = wdata[BIT_FETCH];
                end
                OFS_LINE: begin
                    cfg_d.ctl.line_period = wdata[HI_LSB +: XW];
                    cfg_d.shape.hs_width  = wdata[0 +: XW];
                end
                OFS_FRAME:  cfg_d.ctl.frame_period = wdata[PW-1:0];
                OFS_VSW:    cfg_d.shape.vs_width   = wdata[PW-1:0];
                OFS_DYS:    cfg_d.shape.dy_start   = wdata[PW-1:0];
                OFS_DYE:    cfg_d.shape.dy_end     = wdata[PW-1:0];
                OFS_WYS:    cfg_d.shape.wy_start   = wdata[PW-1:0];
                OFS_WYE:    cfg_d.shape.wy_end     = wdata[PW-1:0];
                OFS_DX: begin
                    cfg_d.shape.dx_last  = wdata[HI_LSB +: XW];
                    cfg_d.shape.dx_first = wdata[0 +: XW];
                end
                OFS_WX: begin
                    cfg_d.shape.wx_end   = wdata[HI_LSB +: XW];
                    cfg_d.shape.wx_start = wdata[0 +: XW];
                end
                OFS_BORDER: cfg_d.shape.border    = wdata[CW-1:0];
                OFS_UNDER:  cfg_d.shape.underflow = wdata[CW-1:0];
                OFS_SKEW:   cfg_d.shape.skew      = wdata[PW-1:0];
                OFS_POL:    cfg_d.shape.pol       = wdata[2:0];
                OFS_CNTEN:  cfg_d.ctl.cnt_en      = wdata[1:0];
                OFS_FETCH:  cfg_d.shape.fetch_pos = wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_RUN: rdata[0] = cfg_q.ctl.run;
            OFS_CFG: begin
                rdata[BIT_XWIN]  = cfg_q.shape.xwin_en;
                rdata[BIT_YWIN]  = cfg_q.shape.ywin_en;
                rdata[BIT_FETCH] = cfg_q.shape.fetch_en;
            end
            OFS_LINE: begin
                rdata[HI_LSB +: XW] = cfg_q.ctl.line_period;
                rdata[0 +: XW]      = cfg_q.shape.hs_width;
            end
            OFS_FRAME:  rdata[PW-1:0] = cfg_q.ctl.frame_period;
            OFS_VSW:    rdata[PW-1:0] = cfg_q.shape.vs_width;
            OFS_DYS:    rdata[PW-1:0] = cfg_q.shape.dy_start;
            OFS_DYE:    rdata[PW-1:0] = cfg_q.shape.dy_end;
            OFS_WYS:    rdata[PW-1:0] = cfg_q.shape.wy_start;
            OFS_WYE:    rdata[PW-1:0] = cfg_q.shape.wy_end;
            OFS_DX: begin
                rdata[HI_LSB +: XW] = cfg_q.shape.dx_last;
                rdata[0 +: XW]      = cfg_q.shape.dx_first;
            end
            OFS_WX: begin
                rdata[HI_LSB +: XW] = cfg_q.shape.wx_end;
                rdata[0 +: XW]      = cfg_q.shape.wx_start;
            end
            OFS_BORDER: rdata[CW-1:0] = cfg_q.shape.border;
            OFS_UNDER:  rdata[CW-1:0] = cfg_q.shape.underflow;
            OFS_SKEW:   rdata[PW-1:0] = cfg_q.shape.skew;
            OFS_POL:    rdata[2:0]    = cfg_q.shape.pol;
            OFS_CNTEN:  rdata[1:0]    = cfg_q.ctl.cnt_en;
            OFS_FCNT:   rdata[FW-1:0] = frame_cnt;
            OFS_LCNT:   rdata[XW-1:0] = line_cnt;
            OFS_FETCH:  rdata[PW-1:0] = cfg_q.shape.fetch_pos;
            default: ;
        endcase
    end

    assign cfg_o = cfg_q;

    // R1: a border color write is held from the next edge on
    a_r1_border_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_BORDER) |=> (cfg_q.shape.border == $past(wdata[CW-1:0])));
endmodule

// File: rtl/dte_position.sv
module dte_position
    import dte_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  dte_ctl_t      ctl,
    output logic [XW-1:0] x_o,
    output logic [PW-1:0] pos_o,
    output logic [FW-1:0] frame_cnt_o,
    output logic [XW-1:0] line_cnt_o
);
    typedef struct packed {
        logic [XW-1:0] x;
        logic [PW-1:0] pos;
        logic [FW-1:0] fcnt;
        logic [XW-1:0] lcnt;
    } pos_st_t;

    pos_st_t       st_d, st_q;
    logic [XW-1:0] x_end;
    logic [PW-1:0] p_end;
    logic          x_last, p_last;

    always_comb begin
        x_end  = (ctl.line_period == '0) ? '0 : ctl.line_period - XW'(1);
        p_end  = (ctl.frame_period == '0) ? '0 : ctl.frame_period - PW'(1);
        x_last = (st_q.x >= x_end);
        p_last = (st_q.pos >= p_end);
        st_d   = st_q;
        if (!ctl.run) begin
            st_d = '0;
        end else begin
            st_d.pos = p_last ? '0 : st_q.pos + PW'(1);
            st_d.x   = (p_last || x_last) ? '0 : st_q.x + XW'(1);
            if (p_last && ctl.cnt_en[0])
                st_d.fcnt = st_q.fcnt + FW'(1);
            if (p_last)
                st_d.lcnt = '0;
            else if (x_last && ctl.cnt_en[1])
                st_d.lcnt = st_q.lcnt + XW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_o         = st_q.x;
    assign pos_o       = st_q.pos;
    assign frame_cnt_o = st_q.fcnt;
    assign line_cnt_o  = st_q.lcnt;

    // R2: stopping clears every position and counter at the next edge
    a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.run |=> (pos_o == '0 && x_o == '0 && frame_cnt_o == '0 && line_cnt_o == '0));

    // R3: away from the wrap point the frame position steps by one
    a_r3_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.run && !p_last) |=> (pos_o == $past(pos_o) + PW'(1)));
endmodule

// File: rtl/dte_outstage.sv
module dte_outstage
    import dte_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  dte_shape_t    shape,
    input  logic [XW-1:0] x_i,
    input  logic [PW-1:0] pos_i,
    input  logic [CW-1:0] pix_in,
    input  logic          pix_valid,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          req_o,
    output logic          border_o,
    output logic          fetch_o,
    output logic          underflow_o,
    output logic [CW-1:0] pix_o,
    output logic [XW-1:0] x_o,
    output logic [PW-1:0] pos_o
);
    typedef struct packed {
        logic          hs;
        logic          vs;
        logic          de;
        logic          req;
        logic          bd;
        logic          fetch;
        logic [XW-1:0] x;
        logic [PW-1:0] pos;
    } out_st_t;

    out_st_t     o_d, o_q;
    logic [PW:0] vs_stop;
    logic        hs_raw, vs_raw, de_raw, in_xwin, in_ywin, in_win;

    always_comb begin
        vs_stop = {1'b0, shape.skew} + {1'b0, shape.vs_width};
        hs_raw  = (x_i < shape.hs_width);
        vs_raw  = (pos_i >= shape.skew) && ({1'b0, pos_i} < vs_stop);
        de_raw  = (pos_i >= shape.dy_start) && (pos_i <= shape.dy_end) &&
                  (x_i >= shape.dx_first) && (x_i <= shape.dx_last);
        in_xwin = !shape.xwin_en || ((x_i >= shape.wx_start) && (x_i <= shape.wx_end));
        in_ywin = !shape.ywin_en || ((pos_i >= shape.wy_start) && (pos_i <= shape.wy_end));
        in_win  = in_xwin && in_ywin;

        o_d = '0;
        if (run) begin
            o_d.hs    = hs_raw ^ shape.pol[0];
            o_d.vs    = vs_raw ^ shape.pol[1];
            o_d.de    = de_raw ^ shape.pol[2];
            o_d.req   = de_raw && in_win;
            o_d.bd    = de_raw && !in_win;
            o_d.fetch = shape.fetch_en && (pos_i == shape.fetch_pos);
            o_d.x     = x_i;
            o_d.pos   = pos_i;
        end else begin
            o_d.hs = shape.pol[0];
            o_d.vs = shape.pol[1];
            o_d.de = shape.pol[2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hsync_o     = o_q.hs;
    assign vsync_o     = o_q.vs;
    assign de_o        = o_q.de;
    assign req_o       = o_q.req;
    assign border_o    = o_q.bd;
    assign fetch_o     = o_q.fetch;
    assign x_o         = o_q.x;
    assign pos_o       = o_q.pos;
    assign underflow_o = o_q.req && !pix_valid;
    assign pix_o       = o_q.bd  ? shape.border :
                         o_q.req ? (pix_valid ? pix_in : shape.underflow) : '0;

    // R9: while stopped the sync and enable outputs rest at the polarity bits
    a_r9_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hsync_o == $past(shape.pol[0]) && vsync_o == $past(shape.pol[1]) &&
                  de_o == $past(shape.pol[2])));

    // R7: a pixel is either requested or bordered, never both
    a_r7_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_o && border_o));

    // R8: a missing requested pixel is replaced by the underflow color
    a_r8_underflow_color: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> (pix_o == shape.underflow));

    // R10: the fetch trigger lasts one clock unless the position is frozen
    a_r10_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> (!fetch_o || pos_o == $past(pos_o)));
endmodule

// File: rtl/disp_timing_engine.sv
module disp_timing_engine
    import dte_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [CW-1:0] pix_in,
    input  logic          pix_valid,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          pix_req_o,
    output logic          border_o,
    output logic          fetch_o,
    output logic          underflow_o,
    output logic [CW-1:0] pix_o,
    output logic [XW-1:0] pos_x_o,
    output logic [PW-1:0] pos_f_o
);
    dte_cfg_t      cfg;
    logic [XW-1:0] cur_x;
    logic [PW-1:0] cur_pos;
    logic [FW-1:0] frame_cnt;
    logic [XW-1:0] line_cnt;

    dte_regbank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .frame_cnt (frame_cnt),
        .line_cnt  (line_cnt),
        .rdata     (reg_rdata),
        .cfg_o     (cfg)
    );

    dte_position u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (cfg.ctl),
        .x_o         (cur_x),
        .pos_o       (cur_pos),
        .frame_cnt_o (frame_cnt),
        .line_cnt_o  (line_cnt)
    );

    dte_outstage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (cfg.ctl.run),
        .shape       (cfg.shape),
        .x_i         (cur_x),
        .pos_i       (cur_pos),
        .pix_in      (pix_in),
        .pix_valid   (pix_valid),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .de_o        (de_o),
        .req_o       (pix_req_o),
        .border_o    (border_o),
        .fetch_o     (fetch_o),
        .underflow_o (underflow_o),
        .pix_o       (pix_o),
        .x_o         (pos_x_o),
        .pos_o       (pos_f_o)
    );
endmodule

// File: tb/tb_disp_timing_engine.sv
module tb_disp_timing_engine;
    localparam int CLK_P = 10;
    localparam logic [23:0] PIX    = 24'hA5C3E1;
    localparam logic [23:0] BORDER = 24'h123456;
    localparam logic [23:0] UNDER  = 24'h0F0F0F;
    localparam int LP = 20;
    localparam int FP = 140;

    // {t[8:0], hs, vs, de, req, border, fetch, pix_valid}; R4 R5 R6 R7 R10 expectations
    localparam int NV = 20;
    localparam logic [15:0] VEC [NV] = '{
        {9'd0,   7'b1100001}, {9'd5,   7'b0100001}, {9'd41,  7'b1000001},
        {9'd45,  7'b0010101}, {9'd54,  7'b0010101}, {9'd55,  7'b0000001},
        {9'd66,  7'b0010101}, {9'd67,  7'b0011001}, {9'd70,  7'b0011000},
        {9'd71,  7'b0011001}, {9'd72,  7'b0010101}, {9'd105, 7'b0010101},
        {9'd119, 7'b0000001}, {9'd121, 7'b1000001}, {9'd130, 7'b0000011},
        {9'd131, 7'b0000001}, {9'd139, 7'b0000001}, {9'd141, 7'b1100001},
        {9'd207, 7'b0011001}, {9'd270, 7'b0000011}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [23:0] pix_in = PIX;
    logic        pix_valid = 1'b1;
    logic        hsync_o, vsync_o, de_o, pix_req_o, border_o, fetch_o, underflow_o;
    logic [23:0] pix_o;
    logic [15:0] pos_x_o;
    logic [31:0] pos_f_o;

    int checks = 0;
    int errors = 0;
    int t = 0;

    always #(CLK_P/2) clk = ~clk;

    disp_timing_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in(pix_in),
        .pix_valid(pix_valid), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .pix_req_o(pix_req_o), .border_o(border_o), .fetch_o(fetch_o),
        .underflow_o(underflow_o), .pix_o(pix_o), .pos_x_o(pos_x_o), .pos_f_o(pos_f_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0d)", tag, act, exp, t);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic adv_to(input int target);
        while (t < target) begin
            @(negedge clk);
            t++;
        end
        #1;
    endtask

    task automatic start_run();
        wr(12'h000, 32'd1);
        @(negedge clk);
        t = 0;
    endtask

    function automatic logic [5:0] flags();
        return {hsync_o, vsync_o, de_o, pix_req_o, border_o, fetch_o};
    endfunction

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R2: reset state is stopped with idle outputs
        check("R2 reset flags", {26'd0, flags()}, 32'd0);
        check("R2 reset pos", pos_f_o, 32'd0);
        rd_check("R2 reset frame count", 12'h0AC, 32'd0);

        // R1: readback and unmapped offsets
        wr(12'h044, {8'hFF, BORDER});
        rd_check("R1 border readback", 12'h044, {8'h00, BORDER});
        wr(12'h0C0, 32'hFFFF_FFFF);
        rd_check("R1 unmapped reads zero", 12'h0C0, 32'd0);
        wr(12'h008, {16'd20, 16'd2});
        rd_check("R1 line register", 12'h008, {16'd20, 16'd2});

        wr(12'h00C, FP);
        wr(12'h014, 32'd20);
        wr(12'h01C, 32'd40);
        wr(12'h024, 32'd119);
        wr(12'h02C, 32'd60);
        wr(12'h034, 32'd99);
        wr(12'h03C, {16'd14, 16'd5});
        wr(12'h040, {16'd11, 16'd7});
        wr(12'h048, {8'h00, UNDER});
        wr(12'h04C, 32'd0);
        wr(12'h050, 32'd0);
        wr(12'h0A8, 32'd3);
        wr(12'h170, 32'd130);
        wr(12'h004, 32'hE000_0000);
        rd_check("R1 config bits", 12'h004, 32'hE000_0000);

        start_run();
        for (int i = 0; i < NV; i++) begin
            int vt;
            logic [5:0] ef;
            logic [23:0] ep;
            vt = int'(VEC[i][15:7]);
            ef = VEC[i][6:1];
            while (t < vt) begin
                @(negedge clk);
                t++;
            end
            pix_valid = VEC[i][0];
            #1;
            // R4 R5 R6 R7 R10: sync, enable, window flags and fetch
            check("R4/R5/R6/R7/R10 flags", {26'd0, flags()}, {26'd0, ef});
            // R3: position outputs follow the bench cycle index
            check("R3 frame position", pos_f_o, 32'(t % FP));
            check("R3 x position", {16'd0, pos_x_o}, 32'(t % LP));
            // R8: pixel mux
            ep = ef[1] ? BORDER : (ef[2] ? (VEC[i][0] ? PIX : UNDER) : 24'd0);
            check("R8 pixel value", {8'd0, pix_o}, {8'd0, ep});
            check("R8 underflow flag", {31'd0, underflow_o}, {31'd0, ef[2] & ~VEC[i][0]});
        end
        pix_valid = 1'b1;
        #1;
        // R11: counters reflect position t+1
        rd_check("R11 frame count", 12'h0AC, 32'((t + 1) / FP));
        rd_check("R11 line count", 12'h0B0, 32'(((t + 1) % FP) / LP));

        // R2: stop clears counters and idles outputs
        wr(12'h000, 32'd0);
        @(negedge clk);
        #1;
        check("R2 stop pos", pos_f_o, 32'd0);
        check("R2 stop flags", {26'd0, flags()}, 32'd0);
        rd_check("R2 stop frame count", 12'h0AC, 32'd0);
        rd_check("R2 stop line count", 12'h0B0, 32'd0);

        // R9: idle levels follow polarity
        wr(12'h050, 32'd7);
        @(negedge clk);
        #1;
        check("R9 idle inverted", {29'd0, hsync_o, vsync_o, de_o}, 32'd7);

        // R5 R7 R9 R11: skew, windows off, inverted outputs, line count only
        wr(12'h04C, 32'd3);
        wr(12'h004, 32'd0);
        wr(12'h0A8, 32'd2);
        start_run();
        adv_to(1);
        check("R9 R4 t1", {26'd0, flags()}, {26'd0, 6'b011000});
        adv_to(2);
        check("R9 R5 t2 before skew", {26'd0, flags()}, {26'd0, 6'b111000});
        adv_to(3);
        check("R5 vsync starts at skew", {26'd0, flags()}, {26'd0, 6'b101000});
        adv_to(22);
        check("R5 vsync last", {31'd0, vsync_o}, 32'd0);
        adv_to(23);
        check("R5 vsync ends", {31'd0, vsync_o}, 32'd1);
        adv_to(45);
        check("R7 window off req equals enable", {26'd0, flags()}, {26'd0, 6'b110100});
        check("R8 pass-through pixel", {8'd0, pix_o}, {8'd0, PIX});
        adv_to(199);
        rd_check("R11 frame count disabled", 12'h0AC, 32'd0);
        rd_check("R11 line count resets at wrap", 12'h0B0, 32'(((t + 1) % FP) / LP));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule